// File: doc/BRIEF.md
# Preset General-Purpose Register Bank

This block is the architectural register store of a small 32-bit load/store core. It holds a parameterised number of word-wide entries. Two read ports return data combinationally from their addresses, so the decode stage can fetch both source operands in the same cycle. One write port commits a word on the rising clock edge whenever its enable is high. Entry zero is a constant: it reads as zero on both ports, and any write aimed at it is discarded.

A synchronous, active-high reset loads a preset value into every entry. General entries take all ones. The stack-pointer entry takes a fixed base address, the return-address entry takes all ones, and entry zero stays zero. Reset wins over a write in the same cycle.

A build-time switch adds a same-cycle bypass. When it is on, a read port whose address matches the active write returns the incoming word, so a writer in the last stage and a reader in decode do not need an extra stall cycle. When it is off, the ports show only committed contents.

Top module: `gpr_bank`

## Requirements
- R1: After a cycle with reset high, every entry other than 0, 29 and 31 reads 0xFFFFFFFF on both ports until it is written.
- R2: After reset, entry 29 reads 0x01000000 until it is written.
- R3: After reset, entry 31 reads 0xFFFFFFFF until it is written.
- R4: Address 0 reads 0 on both ports at all times. A write to address 0 has no effect, including through the bypass.
- R5: With write enable high and reset low at a rising edge, the addressed nonzero entry holds the write data from the next cycle on.
- R6: With write enable low, no entry changes, whatever the write address and data are.
- R7: The two read ports are independent: each returns the entry at its own address in the same cycle, including when both addresses are equal.
- R8: With the bypass on, while write enable is high and reset is low, a read port whose nonzero address equals the write address returns the write data in that same cycle.
- R9: When reset and write enable are both high in one cycle, the write is dropped and the entry takes its preset value. The bypass is not applied in that cycle.
- R10: With the bypass off, a same-cycle read of the entry being written returns the old contents, and the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset that loads the presets |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Entry index for the write |
| wr_data | input | 32 | Word to write |
| rd_a_addr | input | 5 | Entry index for read port A |
| rd_a_data | output | 32 | Combinational read data, port A |
| rd_b_addr | input | 5 | Entry index for read port B |
| rd_b_data | output | 32 | Combinational read data, port B |

## Verification
The bench builds two copies with the default 32 entries of 32 bits and drives them with the same stimulus. The first copy has the bypass on. The second has it off, so one run covers both the same-cycle forwarding path and the committed-only read behaviour. The default size lets the bench sweep every index, including the three entries with special presets, both right after reset and after a long pseudo-random run of writes. The reset-versus-write collision is aimed at the stack-pointer entry, so a dropped write is visible as a difference from the preset base address.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    // Where a read port takes its word from
    typedef enum logic [1:0] {
        SRC_ZERO   = 2'd0,
        SRC_BYPASS = 2'd1,
        SRC_STORE  = 2'd2
    } gpr_src_e;

endpackage

// File: rtl/gpr_preset_gen.sv
module gpr_preset_gen #(
    parameter int                 DEPTH      = 32,
    parameter int                 WIDTH      = 32,
    parameter int                 SP_IDX     = 29,
    parameter int                 RA_IDX     = 31,
    parameter logic [WIDTH-1:0]   SP_PRESET  = 32'h0100_0000,
    parameter logic [WIDTH-1:0]   RA_PRESET  = '1,
    parameter logic [WIDTH-1:0]   GEN_PRESET = '1
) (
    output logic [DEPTH-1:0][WIDTH-1:0] preset_vals
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_preset
        if (i == 0) begin : g_zero
            assign preset_vals[i] = '0;
        end else if (i == SP_IDX) begin : g_sp
            assign preset_vals[i] = SP_PRESET;
        end else if (i == RA_IDX) begin : g_ra
            assign preset_vals[i] = RA_PRESET;
        end else begin : g_gen
            assign preset_vals[i] = GEN_PRESET;
        end
    end

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int WIDTH     = 32,
    parameter bit BYPASS_EN = 1'b1,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WIDTH-1:0]            wr_data,
    input  logic [DEPTH-1:0][WIDTH-1:0] store,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [WIDTH-1:0]            rd_data
);

    gpr_src_e src;
    logic     fwd_hit;

    assign fwd_hit = BYPASS_EN && wr_en && !rst && (wr_addr == rd_addr);

    always_comb begin
        if (rd_addr == '0) begin
            src = SRC_ZERO;
        end else if (fwd_hit) begin
            src = SRC_BYPASS;
        end else begin
            src = SRC_STORE;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ZERO:   rd_data = '0;
            SRC_BYPASS: rd_data = wr_data;
            default:    rd_data = store[rd_addr];
        endcase
    end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
    parameter int               DEPTH      = 32,
    parameter int               WIDTH      = 32,
    parameter bit               BYPASS_EN  = 1'b1,
    parameter int               SP_IDX     = 29,
    parameter int               RA_IDX     = 31,
    parameter logic [WIDTH-1:0] SP_PRESET  = 32'h0100_0000,
    parameter logic [WIDTH-1:0] RA_PRESET  = '1,
    parameter logic [WIDTH-1:0] GEN_PRESET = '1,
    localparam int              ADDR_W     = $clog2(DEPTH),
    localparam int              N_PORTS    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [WIDTH-1:0]  rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [WIDTH-1:0]  rd_b_data
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] ent;
    } bank_t;

    bank_t st_d, st_q;

    logic [DEPTH-1:0][WIDTH-1:0]   preset_vals;
    logic [N_PORTS-1:0][ADDR_W-1:0] port_addr;
    logic [N_PORTS-1:0][WIDTH-1:0]  port_data;

    gpr_preset_gen #(
        .DEPTH      (DEPTH),
        .WIDTH      (WIDTH),
        .SP_IDX     (SP_IDX),
        .RA_IDX     (RA_IDX),
        .SP_PRESET  (SP_PRESET),
        .RA_PRESET  (RA_PRESET),
        .GEN_PRESET (GEN_PRESET)
    ) i_presets (
        .preset_vals (preset_vals)
    );

    // Next-state: reset loads presets and outranks any write
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ent = preset_vals;
        end else if (wr_en && (wr_addr != '0)) begin
            st_d.ent[wr_addr] = wr_data;
        end
        st_d.ent[0] = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign port_addr[0] = rd_a_addr;
    assign port_addr[1] = rd_b_addr;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        gpr_read_port #(
            .DEPTH     (DEPTH),
            .WIDTH     (WIDTH),
            .BYPASS_EN (BYPASS_EN)
        ) i_rd (
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .store   (st_q.ent),
            .rd_addr (port_addr[p]),
            .rd_data (port_data[p])
        );
    end

    assign rd_a_data = port_data[0];
    assign rd_b_data = port_data[1];

endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
    parameter int               DEPTH     = 32,
    parameter int               WIDTH     = 32,
    parameter bit               BYPASS_EN = 1'b1,
    parameter int               SP_IDX    = 29,
    parameter int               RA_IDX    = 31,
    parameter logic [WIDTH-1:0] SP_PRESET = 32'h0100_0000,
    parameter logic [WIDTH-1:0] RA_PRESET = '1,
    localparam int              ADDR_W    = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [WIDTH-1:0]  rd_a_data,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [WIDTH-1:0]  rd_b_data
);

    localparam logic [ADDR_W-1:0] SP_A = ADDR_W'(SP_IDX);
    localparam logic [ADDR_W-1:0] RA_A = ADDR_W'(RA_IDX);

    p_zero_a_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == '0) |-> (rd_a_data == '0));

    p_zero_b_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

    p_sp_preset_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_a_addr == SP_A && !(wr_en && wr_addr == SP_A))
        |-> (rd_a_data == SP_PRESET));

    p_ra_preset_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd_b_addr == RA_A && !(wr_en && wr_addr == RA_A))
        |-> (rd_b_data == RA_PRESET));

    p_write_lands_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0)
        |=> ((rd_a_addr == $past(wr_addr) && !(wr_en && wr_addr == rd_a_addr))
             -> (rd_a_data == $past(wr_data))));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en)
        |=> ((rd_b_addr == $past(rd_b_addr) && !(wr_en && wr_addr == rd_b_addr))
             -> (rd_b_data == $past(rd_b_data))));

    if (BYPASS_EN) begin : g_fwd_chk
        p_bypass_r8: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr != '0 && rd_a_addr == wr_addr)
            |-> (rd_a_data == wr_data));
    end

endmodule

bind gpr_bank gpr_bank_chk #(
    .DEPTH     (DEPTH),
    .WIDTH     (WIDTH),
    .BYPASS_EN (BYPASS_EN),
    .SP_IDX    (SP_IDX),
    .RA_IDX    (RA_IDX),
    .SP_PRESET (SP_PRESET),
    .RA_PRESET (RA_PRESET)
) i_gpr_bank_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data)
);

// File: tb/test_gpr_bank.sv
`timescale 1ns/1ps
module test_gpr_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_a_addr = '0;
    logic [4:0]  rd_b_addr = '0;
    logic [31:0] rd_a_data, rd_b_data, raw_a_data, raw_b_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpr_bank i_gpr_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    gpr_bank #(.BYPASS_EN(1'b0)) i_gpr_bank_raw (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_a_data(raw_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(raw_b_data)
    );

    // Reference contents built from the requirements
    logic [31:0] model [32];

    function automatic logic [31:0] preset_of(input int idx);
        if (idx == 0)       return 32'h0;
        else if (idx == 29) return 32'h0100_0000;
        else                return 32'hFFFF_FFFF;
    endfunction

    typedef struct {
        string       req;
        logic [31:0] ea, eb, xa, xb;
    } item_t;

    item_t sb[$];
    event  sample_ev;

    function automatic void cmp(input string req, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endfunction

    // Monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                cmp(it.req, "bypass port A", rd_a_data, it.ea);
                cmp(it.req, "bypass port B", rd_b_data, it.eb);
                cmp({it.req, " R10"}, "raw port A", raw_a_data, it.xa);
                cmp({it.req, " R10"}, "raw port B", raw_b_data, it.xb);
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic r, input logic we, input logic [4:0] wa,
                                           input logic [31:0] wd, input logic [4:0] ra,
                                           input bit fwd);
        if (ra == 0)                          return 32'h0;
        if (fwd && we && !r && wa == ra)      return wd;
        return model[ra];
    endfunction

    // Driver: one cycle of stimulus, pushes the expected reads, updates model
    task automatic step(input string req, input logic r, input logic we, input logic [4:0] wa,
                        input logic [31:0] wd, input logic [4:0] ra, input logic [4:0] rb,
                        input bit check);
        item_t it;
        @(negedge clk);
        rst = r; wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        #0.5;
        if (check) begin
            it.req = req;
            it.ea = exp_rd(r, we, wa, wd, ra, 1'b1);
            it.eb = exp_rd(r, we, wa, wd, rb, 1'b1);
            it.xa = exp_rd(r, we, wa, wd, ra, 1'b0);
            it.xb = exp_rd(r, we, wa, wd, rb, 1'b0);
            sb.push_back(it);
            -> sample_ev;
        end
        #0.5;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < 32; i++) model[i] = preset_of(i);
        end else if (we && wa != 0) begin
            model[wa] = wd;
        end
    endtask

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 32; i++) model[i] = 32'hxxxx_xxxx;
        step("reset", 1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 1'b0);
        step("reset", 1'b1, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 1'b0);

        // R1 R2 R3 R4: every index after reset
        for (int i = 0; i < 16; i++)
            step("R1 R2 R3 R4 reset presets", 1'b0, 1'b0, 5'd0, 32'h0,
                 5'(i), 5'(i + 16), 1'b1);

        // R4: writing address 0 is dropped, also on the same cycle
        step("R4 write zero", 1'b0, 1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, 1'b1);
        step("R4 after zero write", 1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0, 1'b1);

        // R5 R7: writes, then both ports read distinct and equal entries
        step("R5 write", 1'b0, 1'b1, 5'd5, 32'h1234_5678, 5'd1, 5'd2, 1'b1);
        step("R5 write", 1'b0, 1'b1, 5'd6, 32'hA5A5_0F0F, 5'd3, 5'd4, 1'b1);
        step("R5 R7 dual read", 1'b0, 1'b0, 5'd0, 32'h0, 5'd5, 5'd6, 1'b1);
        step("R7 same index", 1'b0, 1'b0, 5'd0, 32'h0, 5'd6, 5'd6, 1'b1);

        // R6: enable low, address and data present
        step("R6 disabled write", 1'b0, 1'b0, 5'd5, 32'hFFFF_0000, 5'd5, 5'd5, 1'b1);
        step("R6 after disabled", 1'b0, 1'b0, 5'd0, 32'h0, 5'd5, 5'd6, 1'b1);

        // R8 R10: same-cycle read of the entry being written
        step("R8 bypass", 1'b0, 1'b1, 5'd7, 32'hCAFE_0007, 5'd7, 5'd8, 1'b1);
        step("R8 bypass B", 1'b0, 1'b1, 5'd31, 32'h0BAD_F00D, 5'd7, 5'd31, 1'b1);
        step("R5 committed", 1'b0, 1'b0, 5'd0, 32'h0, 5'd31, 5'd7, 1'b1);

        // R9: reset and write together on the stack-pointer entry
        step("R9 prep", 1'b0, 1'b1, 5'd29, 32'h5555_AAAA, 5'd0, 5'd0, 1'b1);
        step("R9 collide", 1'b1, 1'b1, 5'd29, 32'h7777_1111, 5'd29, 5'd29, 1'b1);
        step("R9 R2 after", 1'b0, 1'b0, 5'd0, 32'h0, 5'd29, 5'd31, 1'b1);

        // R5 R7 R8: pseudo-random traffic
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 400; n++) begin
            logic [4:0] wa, ra, rb;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            wa = lfsr[4:0];
            ra = lfsr[9] ? wa : lfsr[14:10];
            rb = lfsr[15] ? wa : lfsr[20:16];
            step("R5 R7 R8 random", 1'b0, lfsr[21], wa, {lfsr[7:0], lfsr[31:8]}, ra, rb, 1'b1);
        end

        // R1: final sweep of every entry
        for (int i = 0; i < 16; i++)
            step("R1 R5 final sweep", 1'b0, 1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i), 1'b1);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL all watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule